// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 interrupt source lines and fans them out to four parent interrupt lines and four per-core status views. Each source owns a route byte. Its upper nibble picks the parent lines the source drives and its lower nibble picks the cores that see it. Each source has a trigger mode: active-high level, active-low level, rising edge or falling edge. Each source also has an enable bit. Software sets enable bits through one write-one-to-set register and clears them through a separate write-one-to-clear register.

The sources pass through a two-flop synchronizer before trigger detection. Level sources are pending while their input is at the active level. Edge sources latch a sticky pending flag when the selected edge is seen. Software clears that flag by writing a 1 to the matching bit of the clear register, which also drops the enable. A global status register shows the sources that are pending and enabled. Each core has its own status word, which holds the same set reduced to the sources routed to that core. The parent lines are registered.

The register bus is a single-cycle 32-bit port. A write happens on a cycle with `req_i` and `we_i` high. Read data is combinational from `addr_i`.

Top module: `route_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, polarity bit, edge bit and route byte is 0. The enable register, status register and parent outputs all read 0.
- R2: The route byte of source s sits in the word at address 0x00 + 4*(s/4), in byte lane s%4 (bits 8*(s%4)+7 : 8*(s%4)). A write updates only the lanes whose `be_i` bit is 1, and the byte reads back in the same lane.
- R3: Writing 0x28 sets every enable bit whose data bit is 1 and leaves the other bits unchanged. Reading 0x24 returns the enable mask, with bit s for source s.
- R4: Writing 0x2C clears every enable bit whose data bit is 1 and leaves the other bits unchanged.
- R5: Register 0x30 holds the polarity bits and 0x34 holds the edge bits, one bit per source, and both read back. With edge=0, a source is pending while its input equals its polarity bit (pol=1 active high, pol=0 active low).
- R6: With edge=1, pol=1 selects the rising edge and pol=0 the falling edge. The selected edge sets a sticky pending flag that stays set after the input returns. The opposite edge sets nothing.
- R7: Writing a 1 to bit s of 0x2C clears the sticky pending flag of source s together with its enable bit.
- R8: Reading 0x40 returns the pending AND enabled sources. A pending source that is not enabled shows no status bit and drives no parent.
- R9: Reading 0x50 + 4*c returns the status bits of the sources whose route bit c (bit c of the byte, c = 0..3) is 1.
- R10: Parent output n is 1 when some pending, enabled source has route bit 4+n set. A source with several parent bits drives all of them, and a source with no parent bits drives none.
- R11: A level input change shows in status after the second rising clock edge and on the parent output after the third.
- R12: The sticky pending flag of an edge source is held from cycle to cycle until a clear is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high with req_i |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for route words |
| rdata_o | output | 32 | Read data for addr_i |
| src_i | input | NSRC | Raw interrupt sources |
| parent_irq_o | output | NPAR | Parent interrupt lines |

## Verification
The bench builds the block with its defaults of 32 sources, four parents and four cores, so source 31 in the top byte lane of the last route word can be reached, and so can every core status word. With the full four-plus-four route byte, the bench can cover a source that drives two or four parents, a source routed to cores only, and a source routed to every core. The table loop runs both level polarities against matching and non-matching inputs. Directed tests then count the synchronizer latency edge by edge and run the rising and falling sticky flags through clear and re-enable.

// File: rtl/rlic_pkg.sv
package rlic_pkg;
  localparam logic [7:0] OFF_EN   = 8'h24;
  localparam logic [7:0] OFF_SET  = 8'h28;
  localparam logic [7:0] OFF_CLR  = 8'h2C;
  localparam logic [7:0] OFF_POL  = 8'h30;
  localparam logic [7:0] OFF_EDGE = 8'h34;
  localparam logic [7:0] OFF_STAT = 8'h40;
  localparam logic [3:0] CORE_HI  = 4'h5;

  // encoded as {edge, pol}
  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'b00,
    TRIG_LVL_HI = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_RISE   = 2'b11
  } trig_e;
endpackage

// File: rtl/rlic_sync.sv
module rlic_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rlic_trig.sv
module rlic_trig import rlic_pkg::*; #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] s_i,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] edge_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    trig_e mode;
    logic  prev_q, hit_q, det, lvl;

    assign mode = trig_e'({edge_i[i], pol_i[i]});

    always_comb begin
      det = 1'b0;
      lvl = 1'b0;
      unique case (mode)
        TRIG_LVL_LO: lvl = ~s_i[i];
        TRIG_LVL_HI: lvl = s_i[i];
        TRIG_FALL:   det = prev_q & ~s_i[i];
        TRIG_RISE:   det = ~prev_q & s_i[i];
        default:     lvl = 1'b0;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        hit_q  <= 1'b0;
      end else begin
        prev_q <= s_i[i];
        // clear wins over a same-cycle edge; leaving edge mode drops the flag
        if (clr_i[i] || !edge_i[i]) hit_q <= 1'b0;
        else if (det)               hit_q <= 1'b1;
      end
    end

    assign pend_o[i] = edge_i[i] ? hit_q : lvl;
  end
endmodule

// File: rtl/rlic_route.sv
module rlic_route #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NPAR  = 4,
  parameter int unsigned NCORE = 4
) (
  input  logic [NSRC-1:0][NPAR+NCORE-1:0] route_i,
  input  logic [NSRC-1:0]                 act_i,
  output logic [NPAR-1:0]                 par_o,
  output logic [NCORE-1:0][NSRC-1:0]      core_o
);
  for (genvar n = 0; n < NPAR; n++) begin : g_par
    logic [NSRC-1:0] sel;
    for (genvar s = 0; s < NSRC; s++) begin : g_s
      assign sel[s] = route_i[s][NCORE+n];
    end
    assign par_o[n] = |(sel & act_i);
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar s = 0; s < NSRC; s++) begin : g_s
      assign core_o[c][s] = act_i[s] & route_i[s][c];
    end
  end
endmodule

// File: rtl/route_irq_ctrl.sv
module route_irq_ctrl import rlic_pkg::*; #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NPAR  = 4,
  parameter int unsigned NCORE = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [7:0]      addr_i,
  input  logic [31:0]     wdata_i,
  input  logic [3:0]      be_i,
  output logic [31:0]     rdata_o,
  input  logic [NSRC-1:0] src_i,
  output logic [NPAR-1:0] parent_irq_o
);
  localparam int unsigned RW = NPAR + NCORE;

  logic [NSRC-1:0][RW-1:0]    route_q;
  logic [NSRC-1:0]            en_q, pol_q, edge_q;
  logic [NSRC-1:0]            s_sync, pend, status, set_vec, clr_vec;
  logic [NCORE-1:0][NSRC-1:0] core_view;
  logic [NPAR-1:0]            par_d, par_q;
  logic [7:0][31:0]           route_word;
  logic                       wr;

  assign wr      = req_i & we_i;
  assign set_vec = (wr && addr_i == OFF_SET) ? wdata_i[NSRC-1:0] : '0;
  assign clr_vec = (wr && addr_i == OFF_CLR) ? wdata_i[NSRC-1:0] : '0;

  rlic_sync #(.W(NSRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (s_sync)
  );

  rlic_trig #(.NSRC(NSRC)) u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .s_i   (s_sync),
    .pol_i (pol_q),
    .edge_i(edge_q),
    .clr_i (clr_vec),
    .pend_o(pend)
  );

  assign status = pend & en_q;

  rlic_route #(.NSRC(NSRC), .NPAR(NPAR), .NCORE(NCORE)) u_route (
    .route_i(route_q),
    .act_i  (status),
    .par_o  (par_d),
    .core_o (core_view)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
      par_q   <= '0;
      route_q <= '0;
    end else begin
      en_q  <= (en_q | set_vec) & ~clr_vec;
      par_q <= par_d;
      if (wr && addr_i == OFF_POL)  pol_q  <= wdata_i[NSRC-1:0];
      if (wr && addr_i == OFF_EDGE) edge_q <= wdata_i[NSRC-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (wr && addr_i[7:5] == 3'd0 && addr_i[4:2] == 3'(i / 4) && be_i[i % 4])
          route_q[i] <= wdata_i[8*(i%4) +: RW];
      end
    end
  end

  assign parent_irq_o = par_q;

  for (genvar w = 0; w < 8; w++) begin : g_rw
    for (genvar j = 0; j < 4; j++) begin : g_lane
      if (w * 4 + j < NSRC) begin : g_on
        assign route_word[w][8*j +: 8] = 8'(route_q[w*4+j]);
      end else begin : g_off
        assign route_word[w][8*j +: 8] = 8'h00;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[7:5] == 3'd0) begin
      rdata_o = route_word[addr_i[4:2]];
    end else if (addr_i[7:4] == CORE_HI && addr_i[1:0] == 2'b00) begin
      if (int'(addr_i[3:2]) < NCORE) rdata_o = 32'(core_view[addr_i[3:2]]);
    end else begin
      unique case (addr_i)
        OFF_EN:   rdata_o = 32'(en_q);
        OFF_POL:  rdata_o = 32'(pol_q);
        OFF_EDGE: rdata_o = 32'(edge_q);
        OFF_STAT: rdata_o = 32'(status);
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rlic_chk.sv
module rlic_chk import rlic_pkg::*; #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NPAR  = 4,
  parameter int unsigned NCORE = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [7:0]                 addr_i,
  input logic [31:0]                wdata_i,
  input logic [NSRC-1:0]            en_q,
  input logic [NSRC-1:0]            edge_q,
  input logic [NSRC-1:0]            pend,
  input logic [NSRC-1:0]            clr_vec,
  input logic [NSRC-1:0]            status,
  input logic [NCORE-1:0][NSRC-1:0] core_view,
  input logic [NPAR-1:0]            parent_irq_o
);
  assert_enable_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_SET) |=>
      (en_q == ($past(en_q) | $past(wdata_i[NSRC-1:0]))));

  assert_enable_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_CLR) |=>
      (en_q == ($past(en_q) & ~$past(wdata_i[NSRC-1:0]))));

  assert_edge_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_q & $past(edge_q) & $past(pend) & ~$past(clr_vec) & ~pend) == '0));

  assert_parent_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parent_irq_o != '0) |-> ($past(status) != '0));

  for (genvar c = 0; c < NCORE; c++) begin : g_c
    assert_core_subset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((core_view[c] & ~status) == '0));
  end
endmodule

bind route_irq_ctrl rlic_chk #(.NSRC(NSRC), .NPAR(NPAR), .NCORE(NCORE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .en_q        (en_q),
  .edge_q      (edge_q),
  .pend        (pend),
  .clr_vec     (clr_vec),
  .status      (status),
  .core_view   (core_view),
  .parent_irq_o(parent_irq_o)
);

// File: tb/route_irq_ctrl_test.sv
`timescale 1ns/1ps
module route_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  be = '0;
  logic [31:0] src = '0;
  logic [3:0]  par;
  int          checks = 0, fails = 0;
  logic [31:0] d;

  always #10 clk = ~clk;

  route_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .src_i(src), .parent_irq_o(par)
  );

  typedef struct packed {
    logic [4:0] idx;
    logic [7:0] rt;
    logic       pol;
    logic       in_v;
    logic       act;
    logic [3:0] epar;
    logic [3:0] ecore;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{5'd0,  8'h11, 1'b1, 1'b1, 1'b1, 4'b0001, 4'b0001},
    '{5'd3,  8'h82, 1'b1, 1'b1, 1'b1, 4'b1000, 4'b0010},
    '{5'd9,  8'h34, 1'b0, 1'b0, 1'b1, 4'b0011, 4'b0100},
    '{5'd17, 8'hF8, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000},
    '{5'd31, 8'h0F, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1111},
    '{5'd22, 8'h60, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0000},
    '{5'd14, 8'h51, 1'b0, 1'b0, 1'b1, 4'b0101, 4'b0001},
    '{5'd26, 8'h28, 1'b1, 1'b1, 1'b1, 4'b0010, 4'b1000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] dat, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = dat; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] dat);
    @(negedge clk);
    addr = a;
    #2 dat = rdata;
  endtask

  task automatic wr_route(input int s, input logic [7:0] r);
    wr(8'(4 * (s / 4)), 32'(r) << (8 * (s % 4)), 4'b0001 << (s % 4));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(8'h24, d); chk("R1 enable", d, 0);
    rd(8'h30, d); chk("R1 pol", d, 0);
    rd(8'h34, d); chk("R1 edge", d, 0);
    rd(8'h1C, d); chk("R1 route", d, 0);
    rd(8'h40, d); chk("R1 status", d, 0);
    chk("R1 parent", 32'(par), 0);

    // R2 byte lanes
    wr(8'h04, 32'h00AB0000, 4'b0100);
    rd(8'h04, d); chk("R2 lane2", d, 32'h00AB0000);
    wr(8'h04, 32'hFFFFFF12, 4'b0001);
    rd(8'h04, d); chk("R2 lane0 only", d, 32'h00AB0012);
    wr(8'h04, 32'h0, 4'hF);

    // R3 / R4 set and clear
    wr(8'h28, 32'h000000F0, 4'hF);
    wr(8'h28, 32'h00000F00, 4'hF);
    rd(8'h24, d); chk("R3 set", d, 32'h00000FF0);
    wr(8'h2C, 32'h00000030, 4'hF);
    rd(8'h24, d); chk("R4 clear", d, 32'h00000FC0);
    wr(8'h2C, 32'hFFFFFFFF, 4'hF);

    // R5 readback
    wr(8'h30, 32'hA5A50F0F, 4'hF);
    wr(8'h34, 32'h12345678, 4'hF);
    rd(8'h30, d); chk("R5 pol rb", d, 32'hA5A50F0F);
    rd(8'h34, d); chk("R5 edge rb", d, 32'h12345678);
    wr(8'h34, 32'h0, 4'hF);
    wr(8'h30, 32'h0, 4'hF);

    // level table: R5 R8 R9 R10
    for (int k = 0; k < 8; k++) begin
      wr_route(int'(TBL[k].idx), TBL[k].rt);
      wr(8'h30, 32'(TBL[k].pol) << TBL[k].idx, 4'hF);
      wr(8'h28, 32'h1 << TBL[k].idx, 4'hF);
      src = 32'(TBL[k].in_v) << TBL[k].idx;
      idle(4);
      rd(8'h40, d); chk("R5 R8 table status", d, TBL[k].act ? (32'h1 << TBL[k].idx) : 0);
      chk("R10 table parent", 32'(par), 32'(TBL[k].epar));
      for (int c = 0; c < 4; c++) begin
        rd(8'(8'h50 + 4 * c), d);
        chk("R9 table core", d, TBL[k].ecore[c] ? (32'h1 << TBL[k].idx) : 0);
      end
      wr(8'h2C, 32'hFFFFFFFF, 4'hF);
      wr_route(int'(TBL[k].idx), 8'h00);
      wr(8'h30, 32'h0, 4'hF);
      src = '0;
      idle(3);
    end

    // R8 pending but not enabled
    wr_route(2, 8'h11);
    wr(8'h30, 32'h4, 4'hF);
    src = 32'h4;
    idle(4);
    rd(8'h40, d); chk("R8 disabled status", d, 0);
    chk("R8 disabled parent", 32'(par), 0);
    src = '0;
    wr_route(2, 8'h00);

    // R11 latency: source 1, active high, parent 0
    wr_route(1, 8'h11);
    wr(8'h30, 32'h2, 4'hF);
    wr(8'h28, 32'h2, 4'hF);
    idle(3);
    addr = 8'h40;
    @(negedge clk);
    src = 32'h2;
    @(negedge clk); chk("R11 status after 1 edge", rdata, 0);
    @(negedge clk); chk("R11 status after 2 edges", rdata, 32'h2);
    chk("R11 parent after 2 edges", 32'(par), 0);
    @(negedge clk); chk("R11 parent after 3 edges", 32'(par), 32'h1);
    src = '0;
    wr(8'h2C, 32'hFFFFFFFF, 4'hF);
    wr_route(1, 8'h00);
    wr(8'h30, 32'h0, 4'hF);

    // R6 rising edge on source 5, parent 1, core 0
    wr_route(5, 8'h21);
    wr(8'h30, 32'h20, 4'hF);
    wr(8'h34, 32'h20, 4'hF);
    wr(8'h28, 32'h20, 4'hF);
    idle(4);
    rd(8'h40, d); chk("R6 no edge yet", d, 0);
    src = 32'h20;
    idle(2);
    src = '0;
    idle(5);
    rd(8'h40, d); chk("R6 rise sticky", d, 32'h20);
    chk("R6 rise parent", 32'(par), 32'h2);
    idle(6);
    rd(8'h40, d); chk("R12 still held", d, 32'h20);
    // R7 clear drops flag and enable
    wr(8'h2C, 32'h20, 4'hF);
    rd(8'h40, d); chk("R7 status cleared", d, 0);
    rd(8'h24, d); chk("R7 enable cleared", d, 0);
    wr(8'h28, 32'h20, 4'hF);
    idle(4);
    rd(8'h40, d); chk("R7 no refire after clear", d, 0);
    chk("R7 parent low", 32'(par), 0);
    wr(8'h2C, 32'hFFFFFFFF, 4'hF);
    wr_route(5, 8'h00);

    // R6 falling edge on source 7, core 0
    src = 32'h80;
    wr_route(7, 8'h01);
    wr(8'h30, 32'h0, 4'hF);
    wr(8'h34, 32'h80, 4'hF);
    idle(4);
    wr(8'h28, 32'h80, 4'hF);
    idle(2);
    rd(8'h40, d); chk("R6 fall idle high", d, 0);
    src = '0;
    idle(5);
    rd(8'h40, d); chk("R6 fall sticky", d, 32'h80);
    rd(8'h50, d); chk("R9 fall core0", d, 32'h80);
    src = 32'h80;
    idle(5);
    rd(8'h40, d); chk("R12 held across rise", d, 32'h80);
    // R6 opposite edge ignored: rise on falling-mode source after clear
    wr(8'h2C, 32'h80, 4'hF);
    wr(8'h28, 32'h80, 4'hF);
    src = '0;
    idle(2);
    src = 32'h80;
    wr(8'h2C, 32'h80, 4'hF);
    wr(8'h28, 32'h80, 4'hF);
    idle(5);
    rd(8'h40, d); chk("R6 rise ignored in fall mode", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule